// File: doc/BRIEF.md
# Tachometer Period to RPM Converter

This block turns a fan or motor tachometer pulse train into a revolutions-per-minute figure. A fixed 120 kHz reference tick, supplied as a one-cycle clock enable, advances a period counter. The tachometer line is brought into the clock domain and edge-detected. At each rising edge the number of reference ticks since the previous rising edge is captured. The captured count goes to a sequential divider that computes 3,600,000 divided by the count. This is 60 seconds times 120,000 ticks per second, divided by the tachometer's two pulses per revolution. The quotient is held in a result register that a downstream voter reads.

The voter pulses a start request when it wants a fresh reading. The block lowers ready on that request and raises it again once a new result has been written. A motor that stops produces no edges. When the counter reaches a parameterised tick limit without seeing an edge, the result is forced to zero and a stalled flag is raised. The first interval measured after reset or after a stall does not span a full tachometer period, so it is thrown away.

Top module: `tach_rpm_meter`

## Requirements
- R1: After reset, rpm is 0, ready is 0 and stalled is 0.
- R2: The tachometer line passes through a two-flop synchroniser. Each low-to-high transition held for at least two clock cycles produces exactly one one-cycle edge event.
- R3: The measured period is the number of ref_tick pulses between two consecutive tachometer rising edges, with each tick counted exactly once. The value written to rpm is floor(3,600,000 / period).
- R4: The first rising edge after reset, and the first after a stall, only re-arms the measurement. It produces no rpm write, so rpm and ready keep their values until the following edge completes a period.
- R5: When STALL_TICKS ticks pass with no tachometer rising edge, rpm is written with 0 and stalled goes to 1. stalled returns to 0 when the next computed result is written.
- R6: A start request clears ready on the next cycle. Ready rises on the first rpm write (computed or forced to zero by a stall) in a later cycle. It then stays high until the next start request.
- R7: rpm is updated on every completed measurement whether or not a start request is pending.
- R8: A period of zero ticks (two edges with no ref_tick between them) is ignored. rpm is not written and ready is not raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 120 kHz reference rate |
| tach_in | input | 1 | Raw asynchronous tachometer line |
| start | input | 1 | One-cycle request for a fresh reading |
| rpm | output | RPM_W | Last speed result in revolutions per minute |
| ready | output | 1 | A result has been written since the last start request |
| stalled | output | 1 | No tachometer edge within the stall limit |

## Verification
The embedded assertions check these rules on every cycle:
- An edge event never lasts more than one cycle.
- The period counter never passes its limit.
- No capture of zero reaches the divider, and the divider never runs with a zero divisor.
- rpm is zero whenever stalled is high.
- Ready drops after a start request and otherwise holds once raised.

Only the directed scenarios can show the rest:
- The exact quotient for given tick spacings.
- That the first interval after reset or a stall is discarded.
- That the stall fires after the tick limit.
- That a zero-length period leaves the result and ready untouched.

// File: rtl/tach_rpm_pkg.sv
package tach_rpm_pkg;

    localparam int SEC_PER_MIN = 60;

    typedef enum logic [0:0] {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    // ticks per minute divided by pulses per revolution
    function automatic int rpm_scale(input int tick_hz, input int pulses_per_rev);
        return (SEC_PER_MIN * tick_hz) / pulses_per_rev;
    endfunction

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R2

endmodule

// File: rtl/tach_period_capture.sv
module tach_period_capture #(
    parameter int LIMIT = 120000,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             edge_evt,
    output logic             cap_valid,
    output logic [CNT_W-1:0] cap_period,
    output logic             stall_pulse
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] count_q;
    logic             armed_q;
    logic [CNT_W-1:0] count_inc;

    assign count_inc = count_q + CNT_W'(tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q     <= '0;
            armed_q     <= 1'b0;
            cap_valid   <= 1'b0;
            cap_period  <= '0;
            stall_pulse <= 1'b0;
        end else begin
            cap_valid   <= 1'b0;
            stall_pulse <= 1'b0;
            if (edge_evt) begin
                if (armed_q && (count_q != LIM_V) && (count_inc != '0)) begin
                    cap_valid  <= 1'b1;
                    cap_period <= count_inc;
                end
                armed_q <= 1'b1;
                count_q <= '0;
            end else if (tick && (count_q != LIM_V)) begin
                count_q <= count_inc;
                if (count_inc == LIM_V) begin
                    stall_pulse <= 1'b1;
                    armed_q     <= 1'b0;
                end
            end
        end
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count_q <= LIM_V); // R5
    AST_CAP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> (cap_period != '0)); // R8
    AST_STALL_DISARMS: assert property (@(posedge clk) disable iff (rst)
        stall_pulse |-> !armed_q); // R4

endmodule

// File: rtl/tach_seq_divider.sv
module tach_seq_divider #(
    parameter int NUM   = 3600000,
    parameter int NUM_W = 22,
    parameter int DEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             flush,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    import tach_rpm_pkg::*;

    localparam int               STEP_W = $clog2(NUM_W + 1);
    localparam logic [NUM_W-1:0] NUM_V  = NUM_W'(NUM);

    div_state_e        state_q;
    logic [NUM_W-1:0]  q_q;
    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] steps_q;
    logic [DEN_W:0]    trial;
    logic [DEN_W:0]    diff;
    logic              fits;

    assign trial = {rem_q, q_q[NUM_W-1]};
    assign diff  = trial - {1'b0, den_q};
    assign fits  = trial >= {1'b0, den_q};
    assign quot  = q_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            q_q     <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            steps_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (flush) begin
                state_q <= DIV_IDLE;
            end else if (state_q == DIV_IDLE) begin
                if (start) begin
                    state_q <= DIV_RUN;
                    q_q     <= NUM_V;
                    rem_q   <= '0;
                    den_q   <= den;
                    steps_q <= STEP_W'(NUM_W);
                end
            end else begin
                rem_q   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                q_q     <= {q_q[NUM_W-2:0], fits};
                steps_q <= steps_q - STEP_W'(1);
                if (steps_q == STEP_W'(1)) begin
                    state_q <= DIV_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end

    AST_DIV_DEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == DIV_RUN) |-> (den_q != '0)); // R8
    AST_DIV_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state_q == DIV_RUN)); // R3

endmodule

// File: rtl/tach_rpm_meter.sv
module tach_rpm_meter #(
    parameter int TICK_HZ        = 120000,
    parameter int PULSES_PER_REV = 2,
    parameter int STALL_TICKS    = 120000,
    parameter int RPM_W          = $clog2(tach_rpm_pkg::rpm_scale(TICK_HZ, PULSES_PER_REV) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             tach_in,
    input  logic             start,
    output logic [RPM_W-1:0] rpm,
    output logic             ready,
    output logic             stalled
);
    localparam int RPM_NUM = tach_rpm_pkg::rpm_scale(TICK_HZ, PULSES_PER_REV);
    localparam int CNT_W   = $clog2(STALL_TICKS + 1);

    logic             edge_evt;
    logic             cap_valid;
    logic [CNT_W-1:0] cap_period;
    logic             stall_pulse;
    logic             div_done;
    logic [RPM_W-1:0] div_quot;
    logic             pending_q;
    logic             write_evt;

    tach_sync_edge #(.SYNC_STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (tach_in),
        .rise   (edge_evt)
    );

    tach_period_capture #(.LIMIT(STALL_TICKS), .CNT_W(CNT_W)) u_capture (
        .clk         (clk),
        .rst         (rst),
        .tick        (ref_tick),
        .edge_evt    (edge_evt),
        .cap_valid   (cap_valid),
        .cap_period  (cap_period),
        .stall_pulse (stall_pulse)
    );

    tach_seq_divider #(.NUM(RPM_NUM), .NUM_W(RPM_W), .DEN_W(CNT_W)) u_divider (
        .clk   (clk),
        .rst   (rst),
        .start (cap_valid),
        .flush (stall_pulse),
        .den   (cap_period),
        .done  (div_done),
        .quot  (div_quot)
    );

    assign write_evt = stall_pulse | div_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            rpm     <= '0;
            stalled <= 1'b0;
        end else if (stall_pulse) begin
            rpm     <= '0;
            stalled <= 1'b1;
        end else if (div_done) begin
            rpm     <= div_quot;
            stalled <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready     <= 1'b0;
            pending_q <= 1'b0;
        end else if (start) begin
            ready     <= 1'b0;
            pending_q <= 1'b1;
        end else if (write_evt && pending_q) begin
            ready     <= 1'b1;
            pending_q <= 1'b0;
        end
    end

    AST_STALL_ZERO: assert property (@(posedge clk) disable iff (rst)
        stalled |-> (rpm == '0)); // R5
    AST_READY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready); // R6
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready); // R6

endmodule

// File: tb/tach_rpm_meter_tb.sv
module tach_rpm_meter_tb;

    localparam int STALL_T  = 3000;
    localparam int TICK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        tach_in = 1'b0;
    logic        start = 1'b0;
    logic [21:0] rpm;
    logic        ready;
    logic        stalled;

    logic        tick_en = 1'b0;
    int          tach_k = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    tach_rpm_meter #(.STALL_TICKS(STALL_T)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .tach_in  (tach_in),
        .start    (start),
        .rpm      (rpm),
        .ready    (ready),
        .stalled  (stalled)
    );

    // reference tick: one cycle high every TICK_DIV cycles
    initial begin
        forever begin
            @(negedge clk);
            ref_tick = 1'b0;
            if (tick_en) begin
                repeat (TICK_DIV - 1) @(negedge clk);
                ref_tick = 1'b1;
            end
        end
    end

    // tachometer generator: period of tach_k ticks = 4*tach_k cycles
    initial begin
        forever begin
            @(negedge clk);
            if (tach_k != 0) begin
                automatic int k = tach_k;
                tach_in = 1'b1;
                repeat (2 * k) @(negedge clk);
                tach_in = 1'b0;
                repeat (2 * k - 1) @(negedge clk);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        chk("R1 rpm", int'(rpm), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 stalled", int'(stalled), 0);
    endtask

    task automatic t_first_measure();
        tick_en = 1'b1;
        pulse_start();
        tach_k = 1200;
        wait_cyc(2 * 1200);
        chk("R4 rpm after first edge", int'(rpm), 0);
        chk("R4 ready after first edge", int'(ready), 0);
        wait_cyc(4 * 1200);
        chk("R3 rpm at 1200 ticks", int'(rpm), 3000);
        chk("R6 ready after result", int'(ready), 1);
        chk("R2 single edge per pulse", int'(stalled), 0);
    endtask

    task automatic t_speed_change();
        tach_k = 500;
        wait_cyc(2400 + 3 * 2000);
        chk("R3 rpm at 500 ticks", int'(rpm), 7200);
        chk("R7 rpm updated without start", int'(rpm), 7200);
        chk("R6 ready held without start", int'(ready), 1);
        pulse_start();
        chk("R6 ready cleared by start", int'(ready), 0);
        wait_cyc(4000);
        chk("R6 ready after new result", int'(ready), 1);
        tach_k = 10;
        wait_cyc(2000 + 200);
        chk("R3 rpm at 10 ticks", int'(rpm), 360000);
    endtask

    task automatic t_zero_period();
        int rpm_a;
        tach_k = 0;
        wait_cyc(100);
        tick_en = 1'b0;
        wait_cyc(10);
        tach_in = 1'b1; wait_cyc(5);
        tach_in = 1'b0; wait_cyc(5);
        wait_cyc(60);
        rpm_a = int'(rpm);
        pulse_start();
        tach_in = 1'b1; wait_cyc(5);
        tach_in = 1'b0; wait_cyc(5);
        wait_cyc(60);
        chk("R8 rpm unchanged by zero period", int'(rpm), rpm_a);
        chk("R8 ready not raised by zero period", int'(ready), 0);
    endtask

    task automatic t_stall();
        pulse_start();
        tick_en = 1'b1;
        wait_cyc(STALL_T * TICK_DIV + 200);
        chk("R5 rpm forced to zero", int'(rpm), 0);
        chk("R5 stalled set", int'(stalled), 1);
        chk("R6 ready on stall write", int'(ready), 1);
    endtask

    task automatic t_recover();
        tach_k = 100;
        wait_cyc(200);
        chk("R4 rpm after first edge post-stall", int'(rpm), 0);
        chk("R4 stalled held after first edge", int'(stalled), 1);
        wait_cyc(400);
        chk("R3 rpm at 100 ticks", int'(rpm), 36000);
        chk("R5 stalled cleared by result", int'(stalled), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_measure();
        t_speed_change();
        t_zero_period();
        t_stall();
        t_recover();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule